// File: doc/BRIEF.md
# Six-Stage Pipeline Hazard Controller

This block governs data and control hazards for an in-order integer pipeline whose stages run fetch, decode/register read, ALU1, memory, ALU2, writeback, with one instruction entering per clock. The instruction sitting in decode is presented on the `id_*` inputs every cycle. The controller keeps its own record of what occupies ALU1, memory, ALU2 and writeback. From that record it drives four operand-source selects and a fetch/decode stall with a matching ALU1 bubble. It also raises a redirect when a branch in ALU2 compares as taken.

Each operand is consumed at a different point. Load, store and register-memory add use a plain register as the memory address at ALU1, with no offset add. Store data is consumed in the memory stage. Arithmetic operands and branch compare operands are consumed at ALU2. Results become visible at ALU2: for an arithmetic op or register-memory add this is the ALU2 output, and for a load it is the data returned by memory. A result can therefore be forwarded straight out of ALU2 or out of writeback. The register file writes before it reads, so a same-cycle write and read of one register returns the new value.

A hazard remains only when an address register is produced by the instruction directly ahead. That case costs one bubble. A taken branch discards the instructions in fetch, decode and ALU1. The instruction already in the memory stage completes.

Top module: `pipe_hazard_unit`

## Requirements
- R1: While reset is low and afterwards until instructions arrive, every stage is empty, all four selects read 0, and `stall_fd`, `bubble_a1` and `redirect` are low.
- R2: Class codes on `id_cls` are: 0 none, 1 register-register ALU, 2 load, 3 store, 4 register-memory add, 5 branch (6 and 7 act as none). Address operand `rs1` is used at ALU1 by classes 2, 3 and 4. Store data `rs2` is used in the memory stage by class 3. `rs1` is used at ALU2 by classes 1 and 5, and `rs2` is used at ALU2 by classes 1, 4 and 5. Only classes 1, 2 and 4 write `rd`.
- R3: Select codes are 0 register file, 1 writeback value, 2 ALU2 result, 3 load data held in ALU2. When several older instructions write the register, the nearest one wins: ALU2 before writeback before register file.
- R4: The ALU1 address select and the memory store-data select use code 3 when the producer in ALU2 is a load, code 2 when the producer in ALU2 is another writing class, and code 1 when the producer is in writeback.
- R5: ALU2 operand selects only ever use code 1 or 0. Back-to-back arithmetic, load-then-arithmetic and load-then-register-memory-add pairs never stall.
- R6: `stall_fd` and `bubble_a1` rise in the same cycle when the decode instruction needs an address register that the ALU1 occupant writes. The stall lasts exactly one cycle while decode holds its instruction, and ALU1 is empty in the next cycle.
- R7: Register 0 is never a hazard: it causes no stall and always selects code 0.
- R8: `redirect` is high in the same cycle when ALU2 holds a branch and `br_taken` is high. `br_taken` has no effect otherwise.
- R9: On redirect, the instructions in decode and ALU1 are discarded and never act as forwarding sources. The memory-stage instruction proceeds, and `stall_fd` is held low.
- R10: A decode slot with `id_valid` low, and any class that does not write, never causes a stall or a forward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_cls | input | 3 | Class code of the decode instruction (R2) |
| id_rs1 | input | 5 | First source register (address at ALU1 or ALU2 operand A) |
| id_rs2 | input | 5 | Second source register (store data or ALU2 operand B) |
| id_rd | input | 5 | Destination register |
| br_taken | input | 1 | Branch compare outcome from ALU2 |
| stall_fd | output | 1 | Hold fetch and decode this cycle |
| bubble_a1 | output | 1 | Load an empty slot into ALU1 at the next edge |
| redirect | output | 1 | Taken branch: flush fetch, decode and ALU1 |
| a1_addr_src | output | 2 | Source of the ALU1 address register |
| mem_sdata_src | output | 2 | Source of the memory-stage store data |
| a2_opa_src | output | 2 | Source of ALU2 operand A |
| a2_opb_src | output | 2 | Source of ALU2 operand B |

## Verification
Every output is combinational on the present occupancy and the decode inputs. Stall and redirect are therefore due in the same cycle the triggering instruction sits in decode or ALU2. An instruction accepted at decode in cycle t is in ALU1 at t+1, memory at t+2, ALU2 at t+3 and writeback at t+4, and that is when its selects and its forwarding effects appear. At each cycle, after setting the inputs, the bench computes the expected outputs of that same cycle from its own stage model and queues them. Its monitor samples one nanosecond after the falling edge, which keeps the sample clear of both clock edges, and advances the model only after the rising edge.

// File: rtl/hz_pkg.sv
package hz_pkg;

  parameter int unsigned HZ_REG_W = 5;
  parameter int unsigned HZ_CLS_W = 3;
  parameter int unsigned HZ_SRC_W = 2;

  typedef enum logic [HZ_CLS_W-1:0] {
    CLS_NONE   = 3'd0,
    CLS_ALU    = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_RMADD  = 3'd4,
    CLS_BRANCH = 3'd5
  } hz_cls_e;

  typedef enum logic [HZ_SRC_W-1:0] {
    SRC_RF    = 2'd0,
    SRC_WB    = 2'd1,
    SRC_A2RES = 2'd2,
    SRC_A2LD  = 2'd3
  } hz_src_e;

  typedef struct packed {
    logic                vld;
    hz_cls_e             cls;
    logic [HZ_REG_W-1:0] rs1;
    logic [HZ_REG_W-1:0] rs2;
    logic [HZ_REG_W-1:0] rd;
  } hz_slot_t;

  // class writes a destination and the destination is not register 0
  function automatic logic hz_wen(hz_slot_t s);
    return s.vld && (s.rd != '0) &&
           ((s.cls == CLS_ALU) || (s.cls == CLS_LOAD) || (s.cls == CLS_RMADD));
  endfunction

  function automatic logic hz_use_addr(hz_slot_t s);
    return s.vld && ((s.cls == CLS_LOAD) || (s.cls == CLS_STORE) || (s.cls == CLS_RMADD));
  endfunction

  function automatic logic hz_use_sdata(hz_slot_t s);
    return s.vld && (s.cls == CLS_STORE);
  endfunction

  function automatic logic hz_use_opa(hz_slot_t s);
    return s.vld && ((s.cls == CLS_ALU) || (s.cls == CLS_BRANCH));
  endfunction

  function automatic logic hz_use_opb(hz_slot_t s);
    return s.vld && ((s.cls == CLS_ALU) || (s.cls == CLS_BRANCH) || (s.cls == CLS_RMADD));
  endfunction

endpackage

// File: rtl/hz_rst_sync.sv
module hz_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/hz_pipe_track.sv
module hz_pipe_track
  import hz_pkg::*;
#(
  parameter int unsigned NUM_STG  = 4,
  parameter int unsigned KILL_STG = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  hz_slot_t dec_slot,
  input  logic     hold_bubble,
  input  logic     kill_front,
  output hz_slot_t stg_q [NUM_STG]
);

  hz_slot_t stg_d [NUM_STG];

  for (genvar k = 0; k < NUM_STG; k++) begin : g_stg
    if (k == 0) begin : g_head
      always_comb begin
        if (hold_bubble || kill_front) begin
          stg_d[k] = '0;
        end else begin
          stg_d[k] = dec_slot;
        end
      end
    end else if (k < KILL_STG) begin : g_killable
      always_comb begin
        if (kill_front) begin
          stg_d[k] = '0;
        end else begin
          stg_d[k] = stg_q[k-1];
        end
      end
    end else begin : g_shift
      always_comb begin
        stg_d[k] = stg_q[k-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[k] <= '0;
      end else begin
        stg_q[k] <= stg_d[k];
      end
    end
  end

endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect
  import hz_pkg::*;
(
  input  logic                dec_need_addr,
  input  logic [HZ_REG_W-1:0] dec_addr_reg,
  input  logic                a1_wen,
  input  logic [HZ_REG_W-1:0] a1_rd,
  input  logic                redirect,
  output logic                stall
);

  logic addr_pending;

  always_comb begin
    addr_pending = dec_need_addr && (dec_addr_reg != '0) &&
                   a1_wen && (a1_rd == dec_addr_reg);
    stall        = addr_pending && !redirect;
  end

endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
(
  input  logic                need,
  input  logic [HZ_REG_W-1:0] rsel,
  input  logic                near_wen,
  input  logic [HZ_REG_W-1:0] near_rd,
  input  logic                near_ld,
  input  logic                far_wen,
  input  logic [HZ_REG_W-1:0] far_rd,
  output logic [HZ_SRC_W-1:0] src
);

  always_comb begin
    src = SRC_RF;
    if (need && (rsel != '0)) begin
      if (near_wen && (near_rd == rsel)) begin
        src = near_ld ? SRC_A2LD : SRC_A2RES;
      end else if (far_wen && (far_rd == rsel)) begin
        src = SRC_WB;
      end
    end
  end

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hz_pkg::*;
#(
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                id_valid,
  input  logic [HZ_CLS_W-1:0] id_cls,
  input  logic [HZ_REG_W-1:0] id_rs1,
  input  logic [HZ_REG_W-1:0] id_rs2,
  input  logic [HZ_REG_W-1:0] id_rd,
  input  logic                br_taken,
  output logic                stall_fd,
  output logic                bubble_a1,
  output logic                redirect,
  output logic [HZ_SRC_W-1:0] a1_addr_src,
  output logic [HZ_SRC_W-1:0] mem_sdata_src,
  output logic [HZ_SRC_W-1:0] a2_opa_src,
  output logic [HZ_SRC_W-1:0] a2_opb_src
);

  localparam int unsigned NUM_STG  = 4;
  localparam int unsigned KILL_STG = 2;
  localparam int unsigned STG_A1   = 0;
  localparam int unsigned STG_MEM  = 1;
  localparam int unsigned STG_A2   = 2;
  localparam int unsigned STG_WB   = 3;

  logic     rst_sync_n;
  hz_slot_t dec_slot;
  hz_slot_t stg_q [NUM_STG];
  hz_slot_t a1_s, mem_s, a2_s, wb_s;
  logic     stall_int;
  logic     redirect_int;

  logic                a1_need_addr;
  logic [HZ_REG_W-1:0] a1_addr_reg;
  logic                mem_wen;
  logic [HZ_REG_W-1:0] mem_rd;
  logic                a2_wen, a2_is_ld, wb_wen, a1_wen;

  hz_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  always_comb begin
    dec_slot.vld = id_valid;
    dec_slot.cls = hz_cls_e'(id_cls);
    dec_slot.rs1 = id_rs1;
    dec_slot.rs2 = id_rs2;
    dec_slot.rd  = id_rd;
  end

  hz_pipe_track #(.NUM_STG(NUM_STG), .KILL_STG(KILL_STG)) u_track (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .dec_slot    (dec_slot),
    .hold_bubble (stall_int),
    .kill_front  (redirect_int),
    .stg_q       (stg_q)
  );

  always_comb begin
    a1_s         = stg_q[STG_A1];
    mem_s        = stg_q[STG_MEM];
    a2_s         = stg_q[STG_A2];
    wb_s         = stg_q[STG_WB];
    a1_wen       = hz_wen(a1_s);
    mem_wen      = hz_wen(mem_s);
    mem_rd       = mem_s.rd;
    a2_wen       = hz_wen(a2_s);
    a2_is_ld     = (a2_s.cls == CLS_LOAD);
    wb_wen       = hz_wen(wb_s);
    a1_need_addr = hz_use_addr(a1_s);
    a1_addr_reg  = a1_s.rs1;
    redirect_int = a2_s.vld && (a2_s.cls == CLS_BRANCH) && br_taken;
  end

  hz_stall_detect u_stall (
    .dec_need_addr (hz_use_addr(dec_slot)),
    .dec_addr_reg  (id_rs1),
    .a1_wen        (a1_wen),
    .a1_rd         (a1_s.rd),
    .redirect      (redirect_int),
    .stall         (stall_int)
  );

  // address register consumed at ALU1: producers may sit in ALU2 or writeback
  hz_fwd_sel u_fwd_addr (
    .need     (a1_need_addr),
    .rsel     (a1_addr_reg),
    .near_wen (a2_wen),
    .near_rd  (a2_s.rd),
    .near_ld  (a2_is_ld),
    .far_wen  (wb_wen),
    .far_rd   (wb_s.rd),
    .src      (a1_addr_src)
  );

  // store data consumed in the memory stage
  hz_fwd_sel u_fwd_sdata (
    .need     (hz_use_sdata(mem_s)),
    .rsel     (mem_s.rs2),
    .near_wen (a2_wen),
    .near_rd  (a2_s.rd),
    .near_ld  (a2_is_ld),
    .far_wen  (wb_wen),
    .far_rd   (wb_s.rd),
    .src      (mem_sdata_src)
  );

  // ALU2 operands: the only older stage left is writeback
  hz_fwd_sel u_fwd_opa (
    .need     (hz_use_opa(a2_s)),
    .rsel     (a2_s.rs1),
    .near_wen (1'b0),
    .near_rd  ('0),
    .near_ld  (1'b0),
    .far_wen  (wb_wen),
    .far_rd   (wb_s.rd),
    .src      (a2_opa_src)
  );

  hz_fwd_sel u_fwd_opb (
    .need     (hz_use_opb(a2_s)),
    .rsel     (a2_s.rs2),
    .near_wen (1'b0),
    .near_rd  ('0),
    .near_ld  (1'b0),
    .far_wen  (wb_wen),
    .far_rd   (wb_s.rd),
    .src      (a2_opb_src)
  );

  assign stall_fd  = stall_int;
  assign bubble_a1 = stall_int;
  assign redirect  = redirect_int;

endmodule

// File: rtl/hz_chk.sv
module hz_chk
  import hz_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                id_valid,
  input logic [HZ_REG_W-1:0] id_rs1,
  input logic                stall_fd,
  input logic                redirect,
  input logic [HZ_SRC_W-1:0] a1_addr_src,
  input logic [HZ_SRC_W-1:0] mem_sdata_src,
  input logic                a1_need_addr,
  input logic [HZ_REG_W-1:0] a1_addr_reg,
  input logic                mem_wen,
  input logic [HZ_REG_W-1:0] mem_rd
);

  p_stall_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fd |=> !stall_fd);

  p_stall_empties_a1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fd |=> (a1_addr_src == '0));

  p_addr_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(a1_need_addr && (a1_addr_reg != '0) && mem_wen && (mem_rd == a1_addr_reg)));

  p_stall_not_x0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fd |-> (id_valid && (id_rs1 != '0)));

  p_redirect_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !stall_fd);

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> ((a1_addr_src == '0) && (mem_sdata_src == '0)));

endmodule

bind pipe_hazard_unit hz_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .id_valid      (id_valid),
  .id_rs1        (id_rs1),
  .stall_fd      (stall_fd),
  .redirect      (redirect),
  .a1_addr_src   (a1_addr_src),
  .mem_sdata_src (mem_sdata_src),
  .a1_need_addr  (a1_need_addr),
  .a1_addr_reg   (a1_addr_reg),
  .mem_wen       (mem_wen),
  .mem_rd        (mem_rd)
);

// File: tb/pipe_hazard_unit_tb_top.sv
`timescale 1ns/100ps
module pipe_hazard_unit_tb_top;
  import hz_pkg::*;

  logic                clk;
  logic                rst_n;
  logic                id_valid;
  logic [HZ_CLS_W-1:0] id_cls;
  logic [HZ_REG_W-1:0] id_rs1, id_rs2, id_rd;
  logic                br_taken;
  logic                stall_fd, bubble_a1, redirect;
  logic [HZ_SRC_W-1:0] a1_addr_src, mem_sdata_src, a2_opa_src, a2_opb_src;

  int n_checks = 0;
  int n_errors = 0;

  typedef struct {
    string      tag;
    logic       stall;
    logic       redir;
    logic [1:0] a1;
    logic [1:0] md;
    logic [1:0] oa;
    logic [1:0] ob;
  } exp_t;

  exp_t     exp_q[$];
  hz_slot_t m_stg [4];   // 0 ALU1, 1 memory, 2 ALU2, 3 writeback

  pipe_hazard_unit dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .id_valid      (id_valid),
    .id_cls        (id_cls),
    .id_rs1        (id_rs1),
    .id_rs2        (id_rs2),
    .id_rd         (id_rd),
    .br_taken      (br_taken),
    .stall_fd      (stall_fd),
    .bubble_a1     (bubble_a1),
    .redirect      (redirect),
    .a1_addr_src   (a1_addr_src),
    .mem_sdata_src (mem_sdata_src),
    .a2_opa_src    (a2_opa_src),
    .a2_opb_src    (a2_opb_src)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  // R2 destination rule
  function automatic bit m_wr(hz_slot_t s, logic [HZ_REG_W-1:0] r);
    return s.vld && (r != 0) && (s.rd == r) && (s.cls inside {CLS_ALU, CLS_LOAD, CLS_RMADD});
  endfunction

  // R3 nearest older producer, searched from the consumer's stage outward
  function automatic logic [1:0] m_src(int cons, logic [HZ_REG_W-1:0] r);
    for (int k = cons + 1; k < 4; k++) begin
      if (m_wr(m_stg[k], r)) begin
        if (k == 2) return (m_stg[k].cls == CLS_LOAD) ? 2'd3 : 2'd2;
        if (k == 3) return 2'd1;
        return 2'd0;
      end
    end
    return 2'd0;
  endfunction

  function automatic hz_slot_t mk(hz_cls_e c, int rd, int a, int b);
    hz_slot_t s;
    s.vld = 1'b1;
    s.cls = c;
    s.rd  = HZ_REG_W'(rd);
    s.rs1 = HZ_REG_W'(a);
    s.rs2 = HZ_REG_W'(b);
    return s;
  endfunction

  task automatic step(input hz_slot_t ins, input logic tk, input string tag, output logic held);
    exp_t e;
    logic rd_x, st_x;
    @(negedge clk);
    id_valid = ins.vld;
    id_cls   = ins.cls;
    id_rs1   = ins.rs1;
    id_rs2   = ins.rs2;
    id_rd    = ins.rd;
    br_taken = tk;
    #0.5;
    rd_x = m_stg[2].vld && (m_stg[2].cls == CLS_BRANCH) && tk;
    st_x = !rd_x && ins.vld && (ins.cls inside {CLS_LOAD, CLS_STORE, CLS_RMADD}) &&
           m_wr(m_stg[0], ins.rs1);
    e.tag   = tag;
    e.stall = st_x;
    e.redir = rd_x;
    e.a1 = (m_stg[0].vld && (m_stg[0].cls inside {CLS_LOAD, CLS_STORE, CLS_RMADD})) ?
           m_src(0, m_stg[0].rs1) : 2'd0;
    e.md = (m_stg[1].vld && (m_stg[1].cls == CLS_STORE)) ? m_src(1, m_stg[1].rs2) : 2'd0;
    e.oa = (m_stg[2].vld && (m_stg[2].cls inside {CLS_ALU, CLS_BRANCH})) ?
           m_src(2, m_stg[2].rs1) : 2'd0;
    e.ob = (m_stg[2].vld && (m_stg[2].cls inside {CLS_ALU, CLS_BRANCH, CLS_RMADD})) ?
           m_src(2, m_stg[2].rs2) : 2'd0;
    exp_q.push_back(e);
    held = st_x;
    @(posedge clk);
    m_stg[3] = m_stg[2];
    m_stg[2] = m_stg[1];
    m_stg[1] = rd_x ? '0 : m_stg[0];
    m_stg[0] = (rd_x || st_x || !ins.vld) ? '0 : ins;
  endtask

  task automatic issue(input hz_slot_t ins, input logic tk, input string tag);
    logic h;
    h = 1'b1;
    while (h) step(ins, tk, tag, h);
  endtask

  // monitor: compare one queued expectation per cycle
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(e.tag, "R6 stall",      {1'b0, stall_fd},  {1'b0, e.stall});
        chk(e.tag, "R6 bubble",     {1'b0, bubble_a1}, {1'b0, e.stall});
        chk(e.tag, "R8 redirect",   {1'b0, redirect},  {1'b0, e.redir});
        chk(e.tag, "R4 addr src",   a1_addr_src,       e.a1);
        chk(e.tag, "R4 sdata src",  mem_sdata_src,     e.md);
        chk(e.tag, "R5 opa src",    a2_opa_src,        e.oa);
        chk(e.tag, "R5 opb src",    a2_opb_src,        e.ob);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog R1 act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    hz_slot_t nop, s;
    nop = '0;
    for (int k = 0; k < 4; k++) m_stg[k] = '0;
    rst_n = 1'b0; id_valid = 1'b0; id_cls = '0; id_rs1 = '0; id_rs2 = '0; id_rd = '0;
    br_taken = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset stall", {1'b0, stall_fd}, 2'd0);
    chk("R1", "reset redirect", {1'b0, redirect}, 2'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1", "idle addr src", a1_addr_src, 2'd0);
    chk("R1", "idle opb src", a2_opb_src, 2'd0);
    chk("R1", "idle bubble", {1'b0, bubble_a1}, 2'd0);

    // R6 address produced by the instruction just ahead: one bubble
    issue(mk(CLS_ALU, 1, 2, 3), 1'b0, "R6");
    issue(mk(CLS_LOAD, 4, 1, 0), 1'b0, "R6");
    // R4 ALU2 result to address, load data to store data and to address
    issue(mk(CLS_ALU, 2, 0, 0), 1'b0, "R4");
    issue(nop, 1'b0, "R4");
    issue(mk(CLS_LOAD, 5, 2, 0), 1'b0, "R4");
    issue(mk(CLS_LOAD, 3, 0, 0), 1'b0, "R4");
    issue(mk(CLS_STORE, 0, 9, 3), 1'b0, "R4");
    issue(mk(CLS_LOAD, 8, 0, 0), 1'b0, "R4");
    issue(nop, 1'b0, "R4");
    issue(mk(CLS_LOAD, 10, 8, 0), 1'b0, "R4");
    // R3 two writers of one register: nearest wins
    issue(mk(CLS_ALU, 6, 0, 0), 1'b0, "R3");
    issue(mk(CLS_ALU, 6, 0, 0), 1'b0, "R3");
    issue(mk(CLS_STORE, 0, 11, 6), 1'b0, "R3");
    // R5 and R2: ALU chain, load-use, register-memory add, no stalls
    issue(mk(CLS_ALU, 5, 1, 1), 1'b0, "R5");
    issue(mk(CLS_ALU, 7, 5, 5), 1'b0, "R5");
    issue(mk(CLS_LOAD, 11, 0, 0), 1'b0, "R2");
    issue(mk(CLS_RMADD, 12, 9, 11), 1'b0, "R2");
    issue(mk(CLS_BRANCH, 0, 12, 11), 1'b0, "R2");
    repeat (4) issue(nop, 1'b0, "R2");
    // R7 register 0 never forwards or stalls
    issue(mk(CLS_ALU, 0, 1, 1), 1'b0, "R7");
    issue(mk(CLS_LOAD, 13, 0, 0), 1'b0, "R7");
    issue(mk(CLS_STORE, 0, 0, 0), 1'b0, "R7");
    // R10 invalid slot and non-writing class
    s = mk(CLS_ALU, 14, 0, 0);
    s.vld = 1'b0;
    issue(s, 1'b0, "R10");
    issue(mk(CLS_LOAD, 1, 14, 0), 1'b0, "R10");
    issue(mk(CLS_STORE, 15, 0, 0), 1'b0, "R10");
    issue(mk(CLS_LOAD, 1, 15, 0), 1'b0, "R10");
    repeat (4) issue(nop, 1'b0, "R10");
    // R8 br_taken without a branch in ALU2 has no effect
    issue(mk(CLS_ALU, 3, 0, 0), 1'b1, "R8");
    issue(nop, 1'b1, "R8");
    // R9 taken branch: delay slot survives, two younger discarded
    issue(mk(CLS_BRANCH, 0, 1, 2), 1'b0, "R9");
    issue(mk(CLS_ALU, 16, 0, 0), 1'b0, "R9");
    issue(mk(CLS_ALU, 17, 0, 0), 1'b0, "R9");
    issue(mk(CLS_LOAD, 18, 17, 0), 1'b1, "R9");
    issue(mk(CLS_STORE, 0, 0, 17), 1'b0, "R9");
    issue(mk(CLS_STORE, 0, 0, 16), 1'b0, "R9");
    repeat (4) issue(nop, 1'b0, "R9");

    // mixed traffic over a small register set
    for (int i = 0; i < 1500; i++) begin
      s.vld = ($urandom_range(0, 7) != 0);
      s.cls = hz_cls_e'($urandom_range(0, 5));
      s.rd  = HZ_REG_W'($urandom_range(0, 7));
      s.rs1 = HZ_REG_W'($urandom_range(0, 7));
      s.rs2 = HZ_REG_W'($urandom_range(0, 7));
      issue(s, ($urandom_range(0, 3) == 0), "R3");
    end

    repeat (4) issue(nop, 1'b0, "R1");
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule